// File: doc/BRIEF.md
# Half-Bridge Gate Command Conditioner

This block is the clocked digital front end of a two-channel half-bridge gate driver. It takes the high-side and low-side PWM commands, which arrive asynchronously, and brings each one into the clock domain. It drops any pulse that is shorter than a filter time and then produces two gate-enable levels. The block keeps these levels apart with a fixed dead time and an interlock. It also blocks them while either supply is in undervoltage. The comparators, the level shifter and the output stages are outside the block. Only their digital flags and enables meet it here.

Two undervoltage flags arrive from outside, one for the ground-referenced low-side supply and one for the floating high-side supply. Each flag goes through the same kind of deglitcher as the commands, but with a much longer window. The two channels recover from lockout in different ways. The low channel goes back to its filtered command as soon as the lockout ends. The high channel stays off until a fresh rising edge appears on its command. A variant parameter selects the IGBT timing, the MOSFET timing, or a bypass build. The bypass build uses IGBT filter timing but has no dead time and no interlock. All times are given in nanoseconds and turned into cycle counts from the clock-period parameter, rounding up.

Top module: `hb_gate_conditioner`

## Requirements
- R1: While reset is held and right after it is released, both gate outputs are low.
- R2: Each command input passes through a two-flop synchronizer and a deglitcher of FILT cycles. FILT is ceil(filter time / clock period), with a filter time of 200 ns for the IGBT and bypass builds and 75 ns for the MOSFET build. A level held for fewer than FILT synchronized cycles is dropped, for both high-going and low-going pulses. A level held for FILT cycles or more passes, and the output follows a clean input step FILT+3 cycles after the input changes.
- R3: Outside bypass, an output turns on only after both outputs have been low for DEAD consecutive cycles. DEAD is ceil(dead time / clock period), with a dead time of 380 ns for IGBT and 75 ns for MOSFET, and a minimum of one cycle. When the two commands swap, both outputs are low for exactly DEAD cycles.
- R4: Outside bypass, both outputs are forced low for as long as both filtered commands are high. The outputs are never high together. When the overlap ends, the command that is still high resumes.
- R5: In the bypass build there is no dead time and no interlock. Each output follows its own filtered command, and both may be high at once.
- R6: While the filtered low-side undervoltage flag is set (input high means undervoltage), both outputs are low one cycle later.
- R7: While only the filtered high-side undervoltage flag is set, the high output is low and the low output still follows its command.
- R8: When the low-side undervoltage clears, the low output returns to its filtered command level with no extra condition. It goes high UV+3 cycles after the flag input falls.
- R9: After high-side undervoltage (or reset), the high output turns on only after a new rising edge of the filtered high command, seen while the high-side flag is clear. A command that is held high through the recovery does not turn it on.
- R10: Each undervoltage flag is deglitched over UV = ceil(1800 ns / clock period) cycles, so a dip shorter than that has no effect on the outputs.
- R11: Turn-off has no dead time. An output falls on the clock edge after its filtered command falls, which is FILT+3 cycles after the input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hiCmdIn | input | 1 | High-side PWM command, asynchronous |
| loCmdIn | input | 1 | Low-side PWM command, asynchronous |
| uvLoIn | input | 1 | Low-side supply undervoltage flag, 1 = undervoltage, asynchronous |
| uvHiIn | input | 1 | High-side supply undervoltage flag, 1 = undervoltage, asynchronous |
| hiGateOut | output | 1 | High-side gate enable |
| loGateOut | output | 1 | Low-side gate enable |

## Verification
The bench builds three copies side by side at an 8 ns clock: the default IGBT build (FILT 25, DEAD 48, UV 225), the MOSFET build (FILT 10, DEAD 10) and the bypass build. The pairs of short filter windows make both the one-below and one-above boundary pulses reachable in a few dozen cycles. The long IGBT dead time makes the exact both-low count easy to tell apart from an off-by-one. Running the bypass copy on the same stimulus shows overlap and a zero gap exactly where the other two copies show interlock and dead time.

// File: rtl/hb_cond_pkg.sv
package hb_cond_pkg;

  typedef enum logic [1:0] {
    VAR_IGBT   = 2'd0,
    VAR_MOSFET = 2'd1,
    VAR_BYPASS = 2'd2
  } drv_variant_e;

  localparam int SYNC_STAGES = 2;

  // Filtered events handed from the input path to the gate control
  typedef struct packed {
    logic hiLvl;   // deglitched high command
    logic loLvl;   // deglitched low command
    logic hiRise;  // one-cycle strobe on a rise of hiLvl
    logic uvLo;    // deglitched low-side undervoltage
    logic uvHi;    // deglitched high-side undervoltage
  } cmd_evt_t;

  function automatic int filtNs(drv_variant_e v);
    return (v == VAR_MOSFET) ? 75 : 200;
  endfunction

  function automatic int deadNs(drv_variant_e v);
    case (v)
      VAR_IGBT:   return 380;
      VAR_MOSFET: return 75;
      default:    return 0;
    endcase
  endfunction

  function automatic int nsToCyc(int ns, int periodPs);
    return (ns * 1000 + periodPs - 1) / periodPs;
  endfunction

endpackage

// File: rtl/hb_deglitch.sv
module hb_deglitch #(
  parameter int CYC  = 25,
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic lvlOut
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);

  logic [SYNC-1:0] syncQ;
  logic            synced;
  logic [CW-1:0]   cnt;
  logic            lvlQ;

  assign synced = syncQ[SYNC-1];
  assign lvlOut = lvlQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC-2:0], rawIn};
  end

  // output flips on the CYC-th consecutive cycle of disagreement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      lvlQ <= 1'b0;
    end else if (synced != lvlQ) begin
      if (cnt == CW'(CYC - 1)) begin
        lvlQ <= synced;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/hb_cmd_path.sv
module hb_cmd_path
  import hb_cond_pkg::*;
#(
  parameter int FILT_CYC = 25,
  parameter int UV_CYC   = 225
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     hiIn,
  input  logic     loIn,
  input  logic     uvLoIn,
  input  logic     uvHiIn,
  output cmd_evt_t evt
);
  localparam int N_CH = 4;

  logic [N_CH-1:0] rawVec;
  logic [N_CH-1:0] lvlVec;
  logic            hiPrev;

  // channel order: 0 high cmd, 1 low cmd, 2 low-side uv, 3 high-side uv
  assign rawVec = {uvHiIn, uvLoIn, loIn, hiIn};

  for (genvar g = 0; g < N_CH; g++) begin : gCh
    localparam int C = (g < 2) ? FILT_CYC : UV_CYC;
    hb_deglitch #(.CYC(C), .SYNC(SYNC_STAGES)) uFilt (
      .clk   (clk),
      .rstN  (rstN),
      .rawIn (rawVec[g]),
      .lvlOut(lvlVec[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hiPrev <= 1'b0;
    else       hiPrev <= lvlVec[0];
  end

  always_comb begin
    evt.hiLvl  = lvlVec[0];
    evt.loLvl  = lvlVec[1];
    evt.hiRise = lvlVec[0] & ~hiPrev;
    evt.uvLo   = lvlVec[2];
    evt.uvHi   = lvlVec[3];
  end
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_cond_pkg::*;
#(
  parameter int DEAD_CYC = 48,
  parameter bit BYPASS   = 1'b0
) (
  input  logic     clk,
  input  logic     rstN,
  input  cmd_evt_t evt,
  output logic     hiOut,
  output logic     loOut
);
  logic armed, armedNow;
  logic hiReq, loReq;
  logic hiNext, loNext;
  logic hiQ, loQ;

  assign hiOut = hiQ;
  assign loOut = loQ;

  // high side needs a rising edge seen outside high-side lockout
  assign armedNow = armed | (evt.hiRise & ~evt.uvHi);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          armed <= 1'b0;
    else if (evt.uvHi)  armed <= 1'b0;
    else if (evt.hiRise) armed <= 1'b1;
  end

  assign hiReq = evt.hiLvl & armedNow & ~evt.uvHi & ~evt.uvLo;
  assign loReq = evt.loLvl & ~evt.uvLo;

  if (BYPASS) begin : gBypass
    assign hiNext = hiReq;
    assign loNext = loReq;
  end else begin : gGuard
    localparam int CNT_W = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
    logic [CNT_W-1:0] offCnt;
    logic             ready, overlap;

    assign overlap = evt.hiLvl & evt.loLvl;
    assign ready   = (offCnt >= CNT_W'(DEAD_CYC - 1));

    // cycles both outputs have already spent low
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    offCnt <= '0;
      else if (hiQ | loQ)           offCnt <= '0;
      else if (!ready)              offCnt <= offCnt + 1'b1;
    end

    assign hiNext = hiReq & ~overlap & (hiQ | (~loQ & ready));
    assign loNext = loReq & ~overlap & (loQ | (~hiQ & ready));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ <= 1'b0;
      loQ <= 1'b0;
    end else begin
      hiQ <= hiNext;
      loQ <= loNext;
    end
  end
endmodule

// File: rtl/hb_gate_conditioner.sv
module hb_gate_conditioner
  import hb_cond_pkg::*;
#(
  parameter drv_variant_e VARIANT       = VAR_IGBT,
  parameter int           CLK_PERIOD_PS = 8000,
  parameter int           UV_FILT_NS    = 1800
) (
  input  logic clk,
  input  logic rstN,
  input  logic hiCmdIn,
  input  logic loCmdIn,
  input  logic uvLoIn,
  input  logic uvHiIn,
  output logic hiGateOut,
  output logic loGateOut
);
  localparam int FILT_RAW  = nsToCyc(filtNs(VARIANT), CLK_PERIOD_PS);
  localparam int FILT_CYC  = (FILT_RAW < 1) ? 1 : FILT_RAW;
  localparam int UV_RAW    = nsToCyc(UV_FILT_NS, CLK_PERIOD_PS);
  localparam int UV_CYC    = (UV_RAW < 1) ? 1 : UV_RAW;
  localparam bit BYPASS_EN = (VARIANT == VAR_BYPASS);
  localparam int DEAD_RAW  = nsToCyc(deadNs(VARIANT), CLK_PERIOD_PS);
  localparam int DEAD_CYC  = BYPASS_EN ? 0 : ((DEAD_RAW < 1) ? 1 : DEAD_RAW);

  cmd_evt_t evt;

  hb_cmd_path #(.FILT_CYC(FILT_CYC), .UV_CYC(UV_CYC)) uPath (
    .clk   (clk),
    .rstN  (rstN),
    .hiIn  (hiCmdIn),
    .loIn  (loCmdIn),
    .uvLoIn(uvLoIn),
    .uvHiIn(uvHiIn),
    .evt   (evt)
  );

  hb_gate_ctrl #(.DEAD_CYC(DEAD_CYC), .BYPASS(BYPASS_EN)) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .evt  (evt),
    .hiOut(hiGateOut),
    .loOut(loGateOut)
  );
endmodule

// File: rtl/hb_gate_conditioner_chk.sv
module hb_gate_conditioner_chk
  import hb_cond_pkg::*;
#(
  parameter bit BYPASS   = 1'b0,
  parameter int DEAD_CYC = 48
) (
  input logic     clk,
  input logic     rstN,
  input cmd_evt_t evt,
  input logic     hiOut,
  input logic     loOut
);
  int   lowRun;
  logic armedM;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lowRun <= 0;
    else if (hiOut || loOut) lowRun <= 0;
    else if (lowRun < DEAD_CYC) lowRun <= lowRun + 1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           armedM <= 1'b0;
    else if (evt.uvHi)   armedM <= 1'b0;
    else if (evt.hiRise) armedM <= 1'b1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    (!BYPASS && hiOut) |-> !loOut); // R4

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (!BYPASS && ($rose(hiOut) || $rose(loOut))) |-> (lowRun >= DEAD_CYC)); // R3

  AST_UVLO_ALL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    evt.uvLo |=> (!hiOut && !loOut)); // R6

  AST_UVHI_HI_LOW: assert property (@(posedge clk) disable iff (!rstN)
    evt.uvHi |=> !hiOut); // R7

  AST_HI_REARM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hiOut) |-> $past(armedM || evt.hiRise)); // R9

  AST_HI_TURNOFF: assert property (@(posedge clk) disable iff (!rstN)
    !evt.hiLvl |=> !hiOut); // R11

  AST_LO_TURNOFF: assert property (@(posedge clk) disable iff (!rstN)
    !evt.loLvl |=> !loOut); // R11
endmodule

bind hb_gate_conditioner hb_gate_conditioner_chk #(
  .BYPASS  (BYPASS_EN),
  .DEAD_CYC(DEAD_CYC)
) u_chk (
  .clk  (clk),
  .rstN (rstN),
  .evt  (evt),
  .hiOut(hiGateOut),
  .loOut(loGateOut)
);

// File: tb/hb_gate_conditioner_tb.sv
`timescale 1ns/1ps
module hb_gate_conditioner_tb;
  import hb_cond_pkg::*;

  localparam int PER_PS = 8000;
  localparam int FILT_I = (200 * 1000 + PER_PS - 1) / PER_PS;   // 25
  localparam int FILT_M = (75 * 1000 + PER_PS - 1) / PER_PS;    // 10
  localparam int DEAD_I = (380 * 1000 + PER_PS - 1) / PER_PS;   // 48
  localparam int DEAD_M = (75 * 1000 + PER_PS - 1) / PER_PS;    // 10
  localparam int UVC    = (1800 * 1000 + PER_PS - 1) / PER_PS;  // 225

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hiIn = 1'b0, loIn = 1'b0, uvLoIn = 1'b0, uvHiIn = 1'b0;
  logic dHi, dLo, mHi, mLo, bHi, bLo;
  int   nChk = 0;
  int   nBad = 0;

  always #4 clk = ~clk;

  hb_gate_conditioner u_dut (
    .clk(clk), .rstN(rstN), .hiCmdIn(hiIn), .loCmdIn(loIn),
    .uvLoIn(uvLoIn), .uvHiIn(uvHiIn), .hiGateOut(dHi), .loGateOut(dLo));

  hb_gate_conditioner #(.VARIANT(VAR_MOSFET)) u_mos (
    .clk(clk), .rstN(rstN), .hiCmdIn(hiIn), .loCmdIn(loIn),
    .uvLoIn(uvLoIn), .uvHiIn(uvHiIn), .hiGateOut(mHi), .loGateOut(mLo));

  hb_gate_conditioner #(.VARIANT(VAR_BYPASS)) u_byp (
    .clk(clk), .rstN(rstN), .hiCmdIn(hiIn), .loCmdIn(loIn),
    .uvLoIn(uvLoIn), .uvHiIn(uvHiIn), .hiGateOut(bHi), .loGateOut(bLo));

  task automatic chk(string req, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // drive loIn to lvl for len cycles, then back; report whether outputs reached lvl
  task automatic loPulse(int len, logic lvl, output bit sawD, output bit sawM);
    sawD = 0;
    sawM = 0;
    loIn = lvl;
    for (int i = 0; i < len + 60; i++) begin
      @(negedge clk);
      if (dLo == lvl) sawD = 1;
      if (mLo == lvl) sawM = 1;
      if (i == len - 1) loIn = ~lvl;
    end
  endtask

  task automatic t_reset();
    idle(3);
    chk("R1", "outputs in reset", {dHi, dLo, mHi, mLo, bHi, bLo}, 0);
    rstN = 1'b1;
    idle(1);
    chk("R1", "outputs after release", {dHi, dLo, mHi, mLo, bHi, bLo}, 0);
    idle(80);
  endtask

  task automatic t_filter();
    bit sD, sM;
    loIn = 1'b1;                       // clean step, R2 latency
    idle(FILT_M + 2);
    chk("R2", "mos lo before latency", mLo, 0);
    idle(1);
    chk("R2", "mos lo at latency", mLo, 1);
    idle(FILT_I + 2 - (FILT_M + 3));
    chk("R2", "igbt lo before latency", dLo, 0);
    idle(1);
    chk("R2", "igbt lo at latency", dLo, 1);
    idle(20);
    loPulse(FILT_I - 1, 1'b0, sD, sM);
    chk("R2", "igbt low-going pulse FILT-1 dropped", sD, 0);
    chk("R2", "mos passes same low pulse", sM, 1);
    loPulse(FILT_I + 1, 1'b0, sD, sM);
    chk("R2", "igbt low-going pulse FILT+1 passes", sD, 1);
    loIn = 1'b0;
    idle(60);
    loPulse(FILT_I - 1, 1'b1, sD, sM);
    chk("R2", "igbt high-going pulse FILT-1 dropped", sD, 0);
    loPulse(FILT_I + 1, 1'b1, sD, sM);
    chk("R2", "igbt high-going pulse FILT+1 passes", sD, 1);
    loPulse(FILT_M - 1, 1'b1, sD, sM);
    chk("R2", "mos high-going pulse FILT-1 dropped", sM, 0);
    loPulse(FILT_M + 1, 1'b1, sD, sM);
    chk("R2", "mos high-going pulse FILT+1 passes", sM, 1);
    chk("R2", "igbt ignores mos-length pulse", sD, 0);
  endtask

  task automatic swapGap(logic toHi, string tag);
    int gD = 0, gM = 0, gB = 0;
    hiIn = toHi;
    loIn = ~toHi;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (!dHi && !dLo) gD++;
      if (!mHi && !mLo) gM++;
      if (!bHi && !bLo) gB++;
    end
    chk("R3", {"igbt dead gap ", tag}, gD, DEAD_I);
    chk("R3", {"mos dead gap ", tag}, gM, DEAD_M);
    chk("R5", {"bypass gap ", tag}, gB, 0);
  endtask

  task automatic t_dead();
    loIn = 1'b1;
    idle(100);
    chk("R3", "lo on before swap", {dLo, mLo, bLo}, 3'b111);
    swapGap(1'b1, "lo->hi");
    chk("R3", "hi on after swap", {dHi, mHi, bHi}, 3'b111);
    swapGap(1'b0, "hi->lo");
  endtask

  task automatic t_interlock();
    int both = 0;
    hiIn = 1'b1;                       // lo command still high
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (dHi && dLo) both++;
    end
    chk("R4", "igbt never both high", both, 0);
    chk("R4", "igbt both low in overlap", {dHi, dLo}, 0);
    chk("R4", "mos both low in overlap", {mHi, mLo}, 0);
    chk("R5", "bypass both high in overlap", {bHi, bLo}, 3);
    loIn = 1'b0;
    idle(120);
    chk("R4", "igbt hi resumes after overlap", {dHi, dLo}, 2);
  endtask

  task automatic t_uvlo();
    bit fell = 0;
    uvLoIn = 1'b1;                     // dip shorter than the window
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!dHi) fell = 1;
      if (i == UVC - 30) uvLoIn = 1'b0;
    end
    chk("R10", "short low-side dip ignored", fell, 0);
    uvLoIn = 1'b1;
    idle(UVC + 15);
    chk("R6", "igbt both low in low-side uv", {dHi, dLo}, 0);
    chk("R6", "bypass both low in low-side uv", {bHi, bLo}, 0);
    hiIn = 1'b0;
    loIn = 1'b1;
    idle(60);
    chk("R6", "lo held low in low-side uv", dLo, 0);
    uvLoIn = 1'b0;
    idle(UVC + 2);
    chk("R8", "lo still low before recovery", dLo, 0);
    idle(1);
    chk("R8", "lo follows command on recovery", dLo, 1);
  endtask

  task automatic t_uvhi();
    loIn = 1'b0;
    hiIn = 1'b1;
    idle(120);
    chk("R9", "hi on after fresh edge", dHi, 1);
    uvHiIn = 1'b1;
    idle(UVC + 15);
    chk("R7", "hi low in high-side uv", dHi, 0);
    hiIn = 1'b0;
    loIn = 1'b1;
    idle(120);
    chk("R7", "lo follows in high-side uv", dLo, 1);
    loIn = 1'b0;
    hiIn = 1'b1;
    idle(60);
    uvHiIn = 1'b0;
    idle(UVC + 60);
    chk("R9", "held-high cmd does not rearm igbt", dHi, 0);
    chk("R9", "held-high cmd does not rearm bypass", bHi, 0);
    hiIn = 1'b0;
    idle(40);
    hiIn = 1'b1;
    idle(120);
    chk("R9", "new edge rearms hi", {dHi, bHi}, 3);
  endtask

  task automatic t_turnoff();
    hiIn = 1'b0;
    idle(FILT_I + 2);
    chk("R11", "hi still on before latency", dHi, 1);
    idle(1);
    chk("R11", "hi off at latency", dHi, 0);
  endtask

  initial begin
    t_reset();
    t_filter();
    t_dead();
    t_interlock();
    t_uvlo();
    t_uvhi();
    t_turnoff();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule